// File: doc/BRIEF.md
# Timer Capture/Compare Status Flags

This block keeps the pending-event flags of a small two-channel timer: one flag for counter update, one for the trigger, one capture/compare flag per channel and one overcapture flag per channel. Event strobes arrive from the counter, the trigger logic and the capture edge detectors. Each strobe sets its flag, and software sees the flags as a 16-bit status word.

Software cannot set a flag. It clears a flag by writing 0 to that flag's bit of the status word. For a channel in input mode, a bus read of that channel's capture register also clears the channel's capture/compare flag. A single interrupt request is the OR of all flags, each gated by its own enable bit.

Top module: `tmr_flag_bank`

## Requirements
- R1: After reset the status word is 0x0000, and `irq` is low. Bits 3, 4, 5, 7, 8 and 11 to 15 of the status word always read 0, even after a write of 0xFFFF.
- R2: The flag positions are: update at bit 0, channel-0 capture/compare at bit 1, channel-1 capture/compare at bit 2, trigger at bit 6, channel-0 overcapture at bit 9 and channel-1 overcapture at bit 10. A write to the status address (default 0x4) with a 0 at a flag's position clears that flag. A write with a 1 leaves the flag unchanged and never sets it.
- R3: In output mode (`ch_input_mode[i]`=0), a channel's capture/compare flag is set by `ev_match[i]`. If `cmp_above_reload[i]` is 1, the flag is set by `ev_update` instead, and `ev_match[i]` is ignored. A capture strobe has no effect in output mode.
- R4: In input mode, `ev_capture[i]` sets the channel's capture/compare flag. A read (`bus_rd`) of the channel's capture address (0xD for channel 0, 0xE for channel 1) clears it. In output mode that read clears nothing.
- R5: A channel's overcapture flag is set when a capture occurs in input mode while that channel's capture/compare flag is already 1. It is never set in output mode.
- R6: With `slave_en`=1 and `gated_mode`=0, `ev_trigger` sets the trigger flag. With `gated_mode`=1, only `ev_gate_toggle` (counter start or stop) sets it, and `ev_trigger` is ignored.
- R7: If a hardware set and a write-zero clear reach the same flag in the same cycle, the flag ends up set.
- R8: `irq` is high exactly when some implemented flag is 1 and its bit in `irq_en` is 1. Enable bits at reserved positions have no effect.
- R9: A capture in the same cycle as a read of that channel's capture address leaves the capture/compare flag at 1 and does not set overcapture.
- R10: With `slave_en`=0, neither `ev_trigger` nor `ev_gate_toggle` sets the trigger flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_update | input | 1 | Counter update/overflow strobe |
| ev_trigger | input | 1 | Active trigger edge strobe |
| ev_gate_toggle | input | 1 | Counter start or stop strobe in gated mode |
| slave_en | input | 1 | Slave controller enabled |
| gated_mode | input | 1 | Slave controller is in gated mode |
| ch_input_mode | input | 2 | Per-channel mode, 1 = input capture |
| ev_match | input | 2 | Per-channel counter equals compare value |
| cmp_above_reload | input | 2 | Per-channel compare value exceeds reload value |
| ev_capture | input | 2 | Per-channel capture strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| irq_en | input | 16 | Per-bit interrupt enables |
| status | output | 16 | Status word |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest cases to reach are the ones where several sources act on one channel in the same cycle. Examples are a capture arriving together with a read of the capture register, and a hardware set arriving together with a write-zero clear. The bench first brings the flag to 1 with a capture strobe. On a later cycle it asserts the competing strobes together on one falling edge, so both are sampled at the same rising edge. It then reads back the capture/compare bit and the overcapture bit. Overcapture needs the flag to be pending already, so the bench sends two captures on consecutive cycles with no read between them.

// File: rtl/tmr_flag_bank.sv
module tmr_flag_bank #(
  parameter int AW = 4,
  parameter logic [AW-1:0] SR_ADDR = 4'h4,
  parameter logic [AW-1:0] CAP0_ADDR = 4'hD,
  parameter logic [AW-1:0] CAP1_ADDR = 4'hE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_update,
  input  logic          ev_trigger,
  input  logic          ev_gate_toggle,
  input  logic          slave_en,
  input  logic          gated_mode,
  input  logic [1:0]    ch_input_mode,
  input  logic [1:0]    ev_match,
  input  logic [1:0]    cmp_above_reload,
  input  logic [1:0]    ev_capture,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [15:0]   bus_wdata,
  input  logic [15:0]   irq_en,
  output logic [15:0]   status,
  output logic          irq
);
  localparam int B_UPD = 0;
  localparam int B_CC  = 1;
  localparam int B_TRG = 6;
  localparam int B_OC  = 9;

  logic upd_q, trg_q;
  logic [1:0] cc_q, oc_q;

  wire sr_wr   = bus_wr && (bus_addr == SR_ADDR);
  wire upd_clr = sr_wr && !bus_wdata[B_UPD];
  wire trg_clr = sr_wr && !bus_wdata[B_TRG];
  wire trg_set = slave_en && (gated_mode ? ev_gate_toggle : ev_trigger);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_q <= 1'b0;
      trg_q <= 1'b0;
    end else begin
      upd_q <= ev_update || (upd_q && !upd_clr);
      trg_q <= trg_set   || (trg_q && !trg_clr);
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_ch
    logic cc_r, oc_r;
    wire [AW-1:0] cap_addr = (i == 0) ? CAP0_ADDR : CAP1_ADDR;
    wire cap_rd = bus_rd && (bus_addr == cap_addr) && ch_input_mode[i];
    wire cc_set = ch_input_mode[i] ? ev_capture[i]
                : (cmp_above_reload[i] ? ev_update : ev_match[i]);
    wire cc_clr = (sr_wr && !bus_wdata[B_CC+i]) || cap_rd;
    wire oc_set = ch_input_mode[i] && ev_capture[i] && cc_r && !cap_rd;
    wire oc_clr = sr_wr && !bus_wdata[B_OC+i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cc_r <= 1'b0;
        oc_r <= 1'b0;
      end else begin
        cc_r <= cc_set || (cc_r && !cc_clr);
        oc_r <= oc_set || (oc_r && !oc_clr);
      end
    end

    assign cc_q[i] = cc_r;
    assign oc_q[i] = oc_r;
  end

  assign status = {5'b0, oc_q, 2'b0, trg_q, 3'b0, cc_q, upd_q};
  assign irq    = |(status & irq_en);
endmodule

// File: rtl/tmr_flag_bank_chk.sv
module tmr_flag_bank_chk #(
  parameter int AW = 4,
  parameter logic [AW-1:0] SR_ADDR = 4'h4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_update,
  input logic [1:0]    ch_input_mode,
  input logic [1:0]    ev_capture,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [15:0]   bus_wdata,
  input logic [15:0]   irq_en,
  input logic [15:0]   status,
  input logic          irq
);
  localparam logic [15:0] RESV = 16'hF9B8;

  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (status & RESV) == 16'h0);

  p_wzero_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == SR_ADDR && !bus_wdata[0] && !ev_update) |=> !status[0]);

  p_no_sw_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[0] && !ev_update) |=> !status[0]);

  p_capture_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_input_mode[0] && ev_capture[0]) |=> status[1]);

  p_no_oc_output_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch_input_mode[1] && !status[10]) |=> !status[10]);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_update |=> status[0]);

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(status & irq_en & 16'h0647));
endmodule

bind tmr_flag_bank tmr_flag_bank_chk #(.AW(AW), .SR_ADDR(SR_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_update(ev_update), .ch_input_mode(ch_input_mode),
  .ev_capture(ev_capture), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq_en(irq_en), .status(status), .irq(irq));

// File: tb/tmr_flag_bank_test.sv
module tmr_flag_bank_test;
  logic clk = 0, rst_n = 0;
  logic ev_update = 0, ev_trigger = 0, ev_gate_toggle = 0, slave_en = 0, gated_mode = 0;
  logic [1:0] ch_input_mode = 0, ev_match = 0, cmp_above_reload = 0, ev_capture = 0;
  logic bus_rd = 0, bus_wr = 0;
  logic [3:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0, irq_en = 0;
  logic [15:0] status;
  logic irq;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  tmr_flag_bank uut (.*);

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_sr(logic [15:0] d);
    bus_wr = 1; bus_addr = 4'h4; bus_wdata = d; tick();
    bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(logic [3:0] a);
    bus_rd = 1; bus_addr = a; tick(); bus_rd = 0;
  endtask

  task automatic t_reset();
    chk("R1 reset status", status, 16'h0000);
    chk("R1 reset irq", {15'b0, irq}, 16'h0);
    wr_sr(16'hFFFF);
    chk("R1 reserved stay zero / R2 no sw set", status, 16'h0000);
  endtask

  task automatic t_update_wzc();
    ev_update = 1; tick(); ev_update = 0;
    chk("R2 update flag bit0", status, 16'h0001);
    wr_sr(16'hFFFF);
    chk("R2 write one keeps", status, 16'h0001);
    wr_sr(16'hFFFE);
    chk("R2 write zero clears", status, 16'h0000);
  endtask

  task automatic t_compare();
    ch_input_mode = 2'b00;
    ev_match[0] = 1; tick(); ev_match = 0;
    chk("R3 match sets ch0", status, 16'h0002);
    wr_sr(16'h0000);
    cmp_above_reload[0] = 1;
    ev_match[0] = 1; tick(); ev_match = 0;
    chk("R3 match ignored above reload", status, 16'h0000);
    ev_update = 1; tick(); ev_update = 0;
    chk("R3 overflow sets ch0", status, 16'h0003);
    cmp_above_reload = 0;
    rd(4'hD);
    chk("R4 output-mode read keeps", status, 16'h0003);
    wr_sr(16'h0000);
    ev_capture = 2'b11; tick(); ev_capture = 0;
    ev_capture = 2'b11; tick(); ev_capture = 0;
    chk("R3/R5 capture ignored in output", status, 16'h0000);
  endtask

  task automatic t_capture();
    ch_input_mode = 2'b10;
    ev_capture[1] = 1; tick(); ev_capture = 0;
    chk("R4 capture sets ch1", status, 16'h0004);
    rd(4'hE);
    chk("R4 capture read clears", status, 16'h0000);
    ev_capture[1] = 1; tick(); tick(); ev_capture = 0;
    chk("R5 overcapture ch1", status, 16'h0404);
    wr_sr(16'hFBFF);
    chk("R2 clear oc only", status, 16'h0004);
    wr_sr(16'h0000);
    ch_input_mode = 2'b00;
  endtask

  task automatic t_same_cycle();
    ch_input_mode = 2'b01;
    ev_capture[0] = 1; tick(); ev_capture = 0;
    ev_capture[0] = 1; bus_rd = 1; bus_addr = 4'hD; tick();
    ev_capture = 0; bus_rd = 0;
    chk("R9 capture with read", status, 16'h0002);
    ev_update = 1; bus_wr = 1; bus_addr = 4'h4; bus_wdata = 16'h0000; tick();
    ev_update = 0; bus_wr = 0;
    chk("R7 set wins over clear", status, 16'h0001);
    wr_sr(16'h0000);
    ch_input_mode = 2'b00;
  endtask

  task automatic t_trigger();
    slave_en = 0; ev_trigger = 1; ev_gate_toggle = 1; tick();
    ev_trigger = 0; ev_gate_toggle = 0;
    chk("R10 slave off ignores", status, 16'h0000);
    slave_en = 1; ev_trigger = 1; tick(); ev_trigger = 0;
    chk("R6 trigger edge sets", status, 16'h0040);
    wr_sr(16'hFFBF);
    gated_mode = 1; ev_trigger = 1; tick(); ev_trigger = 0;
    chk("R6 gated ignores edge", status, 16'h0000);
    ev_gate_toggle = 1; tick(); ev_gate_toggle = 0;
    chk("R6 gated start sets", status, 16'h0040);
    wr_sr(16'h0000);
    slave_en = 0; gated_mode = 0;
  endtask

  task automatic t_irq();
    irq_en = 16'hFFFF; tick();
    chk("R8 no flags no irq", {15'b0, irq}, 16'h0);
    irq_en = 16'h0000;
    ev_update = 1; tick(); ev_update = 0;
    chk("R8 disabled", {15'b0, irq}, 16'h0);
    irq_en = 16'h0200; tick();
    chk("R8 other enable", {15'b0, irq}, 16'h0);
    irq_en = 16'h0001; tick();
    chk("R8 enabled", {15'b0, irq}, 16'h1);
    wr_sr(16'h0000);
    chk("R8 cleared", {15'b0, irq}, 16'h0);
    irq_en = 0;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1;
    tick();
    t_reset();
    t_update_wzc();
    t_compare();
    t_capture();
    t_same_cycle();
    t_trigger();
    t_irq();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule